// File: doc/BRIEF.md
# Control and Status Register Bank

This block is a word-organised bank of 32-bit registers behind a simple read/write strobe bus. It gives software five kinds of access in one address map. A configuration word is stored and driven to hardware. A command word turns each written '1' into a single-cycle pulse. A status word is supplied by hardware. A sticky interrupt status word is cleared by writing ones, and an enable mask sits beside it. A fixed build identifier is set by a parameter. An array of data entries returns a hardware value when read and pulses the written word toward hardware when written.

Interrupt status bits are set by per-bit event pulses from hardware. They stay set until software clears them. The block raises a single interrupt line whenever an enabled status bit is set. Read data is registered: it appears one cycle after the read strobe and holds until the next read.

Top module: `ctrl_reg_bank`

## Requirements
- R1: After reset, every stored value, every pulse output, `rdData` and `irqOut` are zero.
- R2: The configuration word (byte address 0x00) reads back the last value written, and `cfgOut` carries that value continuously.
- R3: A write to the command word (0x04) drives the written bits on `cmdPulse` for exactly one cycle, the cycle after the write. Otherwise `cmdPulse` is zero, and reading 0x04 returns zero.
- R4: Reading the status word (0x08) returns the value on `statusIn`. Writes to it have no effect.
- R5: A '1' on bit n of `irqEvent` sets bit n of the interrupt status word (0x0C). The bit stays set, and reads back as '1', until it is cleared.
- R6: Writing the interrupt status word clears each bit where the written data holds '1'. Bits written as '0' keep their value.
- R7: If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R8: The interrupt mask (0x10) reads back the last value written. `irqOut` is '1' exactly when some bit is '1' in both the interrupt status and the mask.
- R9: Reading 0x14 returns the `BUILD_ID` parameter. Writes to it have no effect.
- R10: Array entry i sits at byte address 0x18 + 4*i, for i from 0 to NUM_ENTRIES-1. Reading it returns word i of `entryIn`. Writing it drives the written word on word i of `entryPulse` for one cycle, the cycle after the write, while every other word stays zero.
- R11: Reads from addresses past the array, or with address bits [1:0] not zero, return zero. Writes to them change no register and raise no pulse.
- R12: `rdData` takes the selected value on the clock edge where `rdEn` is high, and holds it while `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Registered read data |
| cfgOut | output | DATA_W | Stored configuration word |
| cmdPulse | output | DATA_W | Single-cycle command bits |
| statusIn | input | DATA_W | Hardware status word |
| irqEvent | input | DATA_W | Per-bit interrupt set pulses |
| irqOut | output | 1 | Combined masked interrupt |
| entryIn | input | NUM_ENTRIES*DATA_W | Hardware values for the array entries, entry i at bits [32i+31:32i] |
| entryPulse | output | NUM_ENTRIES*DATA_W | Single-cycle write words of the array entries |

## Verification
The hardest case to reach is the collision in which one cycle carries both a set event and a clearing write to the same interrupt bit. Ordinary bus traffic never lines these up. The bench therefore drives `irqEvent` and the clearing write on the same falling edge, so the register sees both on one rising edge. It then reads the status back through the scoreboard and watches `irqOut` with the mask enabled. Misaligned and out-of-range writes are followed by reads of the configuration and mask words, which shows they changed nothing.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int ENTRY_IDX_W = 8;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CFG, SEL_CMD, SEL_STATUS, SEL_IRQ, SEL_MASK, SEL_BUILD, SEL_ENTRY
  } regSel_e;

  typedef struct packed {
    logic                   wr;
    logic                   rd;
    regSel_e                sel;
    logic [ENTRY_IDX_W-1:0] entry;
  } busStb_t;
endpackage

// File: rtl/crb_ctrl.sv
module crb_ctrl
  import crb_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_ENTRIES = 30,
  parameter int ENTRY_BASE  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output busStb_t           stb
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             inArray;

  assign wordIdx = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign inArray = (32'(wordIdx) >= ENTRY_BASE) && (32'(wordIdx) < ENTRY_BASE + NUM_ENTRIES);

  always_comb begin
    stb.wr    = wrEn;
    stb.rd    = rdEn;
    stb.entry = '0;
    stb.sel   = SEL_NONE;
    if (aligned) begin
      case (wordIdx)
        IDX_W'(0): stb.sel = SEL_CFG;
        IDX_W'(1): stb.sel = SEL_CMD;
        IDX_W'(2): stb.sel = SEL_STATUS;
        IDX_W'(3): stb.sel = SEL_IRQ;
        IDX_W'(4): stb.sel = SEL_MASK;
        IDX_W'(5): stb.sel = SEL_BUILD;
        default: begin
          if (inArray) begin
            stb.sel   = SEL_ENTRY;
            stb.entry = ENTRY_IDX_W'(32'(wordIdx) - ENTRY_BASE);
          end
        end
      endcase
    end
  end

  // R11: misaligned or out-of-range addresses never select a register
  a_r11_unmapped_none: assert property (@(posedge clk) disable iff (!rstN)
    (!aligned || 32'(wordIdx) >= ENTRY_BASE + NUM_ENTRIES) |-> stb.sel == SEL_NONE);
endmodule

// File: rtl/crb_datapath.sv
module crb_datapath
  import crb_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          NUM_ENTRIES = 30,
  parameter logic [31:0] BUILD_ID    = 32'h5EED_1234
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  busStb_t                       stb,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [DATA_W-1:0]             statusIn,
  input  logic [DATA_W-1:0]             irqEvent,
  input  logic [NUM_ENTRIES*DATA_W-1:0] entryIn,
  output logic [DATA_W-1:0]             rdData,
  output logic [DATA_W-1:0]             cfgOut,
  output logic [DATA_W-1:0]             cmdPulse,
  output logic                          irqOut,
  output logic [NUM_ENTRIES*DATA_W-1:0] entryPulse
);
  logic [DATA_W-1:0] cfgQ, maskQ, irqQ, cmdQ, rdQ, rdNext;
  logic [DATA_W-1:0] entryWord [NUM_ENTRIES];
  logic wrCfg, wrCmd, wrIrq, wrMask, wrEntry;

  assign wrCfg   = stb.wr && stb.sel == SEL_CFG;
  assign wrCmd   = stb.wr && stb.sel == SEL_CMD;
  assign wrIrq   = stb.wr && stb.sel == SEL_IRQ;
  assign wrMask  = stb.wr && stb.sel == SEL_MASK;
  assign wrEntry = stb.wr && stb.sel == SEL_ENTRY;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= '0;
      maskQ <= '0;
      irqQ  <= '0;
      cmdQ  <= '0;
      rdQ   <= '0;
    end else begin
      if (wrCfg)  cfgQ  <= wrData;
      if (wrMask) maskQ <= wrData;
      cmdQ <= wrCmd ? wrData : '0;
      irqQ <= (irqQ & ~(wrIrq ? wrData : '0)) | irqEvent;
      if (stb.rd) rdQ <= rdNext;
    end
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gEntry
    logic [DATA_W-1:0] pulseQ;
    assign entryWord[g] = entryIn[g*DATA_W +: DATA_W];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pulseQ <= '0;
      else       pulseQ <= (wrEntry && stb.entry == ENTRY_IDX_W'(g)) ? wrData : '0;
    end
    assign entryPulse[g*DATA_W +: DATA_W] = pulseQ;
  end

  always_comb begin
    rdNext = '0;
    case (stb.sel)
      SEL_CFG:    rdNext = cfgQ;
      SEL_STATUS: rdNext = statusIn;
      SEL_IRQ:    rdNext = irqQ;
      SEL_MASK:   rdNext = maskQ;
      SEL_BUILD:  rdNext = DATA_W'(BUILD_ID);
      SEL_ENTRY: begin
        for (int k = 0; k < NUM_ENTRIES; k++)
          if (stb.entry == ENTRY_IDX_W'(k)) rdNext = entryWord[k];
      end
      default:    rdNext = '0;
    endcase
  end

  assign rdData   = rdQ;
  assign cfgOut   = cfgQ;
  assign cmdPulse = cmdQ;
  assign irqOut   = |(irqQ & maskQ);

  // R3: no command pulse without a command write in the previous cycle
  a_r3_cmd_single: assert property (@(posedge clk) disable iff (!rstN)
    !wrCmd |=> cmdPulse == '0);
  // R5: status bits stay set unless a clearing write occurs
  a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !wrIrq |=> (irqQ & $past(irqQ)) == $past(irqQ));
  // R7: an event always leaves its bit set, even against a clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    irqEvent != '0 |=> (irqQ & $past(irqEvent)) == $past(irqEvent));
  // R8: the interrupt line needs a set status bit and a set mask bit
  a_r8_irq_needs_src: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (irqQ != '0 && maskQ != '0));
  // R10: array pulses only follow an array write
  a_r10_entry_single: assert property (@(posedge clk) disable iff (!rstN)
    !wrEntry |=> entryPulse == '0);
  // R12: read data holds between reads
  a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rd |=> $stable(rdData));
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import crb_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 32,
  parameter int          NUM_ENTRIES = 30,
  parameter logic [31:0] BUILD_ID    = 32'h5EED_1234
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic                          rdEn,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wrData,
  output logic [DATA_W-1:0]             rdData,
  output logic [DATA_W-1:0]             cfgOut,
  output logic [DATA_W-1:0]             cmdPulse,
  input  logic [DATA_W-1:0]             statusIn,
  input  logic [DATA_W-1:0]             irqEvent,
  output logic                          irqOut,
  input  logic [NUM_ENTRIES*DATA_W-1:0] entryIn,
  output logic [NUM_ENTRIES*DATA_W-1:0] entryPulse
);
  localparam int ENTRY_BASE = 6;

  busStb_t stb;

  crb_ctrl #(.ADDR_W(ADDR_W), .NUM_ENTRIES(NUM_ENTRIES), .ENTRY_BASE(ENTRY_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .stb(stb)
  );

  crb_datapath #(.DATA_W(DATA_W), .NUM_ENTRIES(NUM_ENTRIES), .BUILD_ID(BUILD_ID)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .statusIn(statusIn),
    .irqEvent(irqEvent), .entryIn(entryIn), .rdData(rdData), .cfgOut(cfgOut),
    .cmdPulse(cmdPulse), .irqOut(irqOut), .entryPulse(entryPulse)
  );
endmodule

// File: tb/ctrl_reg_bank_tb.sv
module ctrl_reg_bank_tb;
  localparam int          NE  = 30;
  localparam logic [31:0] BID = 32'h5EED_1234;

  logic clk = 0, rstN = 0, wrEn = 0, rdEn = 0, irqOut;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0, rdData, cfgOut, cmdPulse, statusIn = '0, irqEvent = '0;
  logic [NE*32-1:0] entryIn, entryPulse;

  int tests = 0, fails = 0;
  logic [31:0] expQ [$];
  string       tagQ [$];

  always #10 clk = ~clk;

  ctrl_reg_bank u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .cfgOut(cfgOut), .cmdPulse(cmdPulse), .statusIn(statusIn),
    .irqEvent(irqEvent), .irqOut(irqOut), .entryIn(entryIn), .entryPulse(entryPulse)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic busRead(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk); rdEn = 1; addr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); rdEn = 0;
  endtask

  // monitor: compare registered read data after each read edge
  initial forever begin
    @(posedge clk);
    if (rdEn && rstN) begin
      #5;
      chk(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) entryIn[i*32 +: 32] = 32'hC0DE_0000 + 32'(i) * 32'h111;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rdData", rdData, 0);
    chk("R1 cfgOut", cfgOut, 0);
    chk("R1 cmdPulse", cmdPulse, 0);
    chk("R1 irqOut", {31'b0, irqOut}, 0);
    chk("R1 entryPulse", 32'(entryPulse != '0), 0);
    rstN = 1;
    busRead(8'h00, 0, "R1 cfg read");
    busRead(8'h10, 0, "R1 mask read");
    busRead(8'h0C, 0, "R1 irq read");

    // R2
    busWrite(8'h00, 32'hDEAD_BEEF);
    chk("R2 cfgOut", cfgOut, 32'hDEAD_BEEF);
    busRead(8'h00, 32'hDEAD_BEEF, "R2 cfg readback");

    // R3
    busWrite(8'h04, 32'h0000_0F0F);
    chk("R3 pulse", cmdPulse, 32'h0000_0F0F);
    @(negedge clk);
    chk("R3 pulse gone", cmdPulse, 0);
    busRead(8'h04, 0, "R3 cmd read zero");

    // R4
    statusIn = 32'h1234_5678;
    busRead(8'h08, 32'h1234_5678, "R4 status");
    busWrite(8'h08, 32'hFFFF_FFFF);
    busRead(8'h08, 32'h1234_5678, "R4 status after write");

    // R5
    @(negedge clk); irqEvent = 32'h5;
    @(negedge clk); irqEvent = 0;
    busRead(8'h0C, 32'h5, "R5 irq set");
    repeat (4) @(negedge clk);
    busRead(8'h0C, 32'h5, "R5 irq sticky");

    // R8
    chk("R8 irqOut masked", {31'b0, irqOut}, 0);
    busWrite(8'h10, 32'h4);
    chk("R8 irqOut enabled", {31'b0, irqOut}, 1);
    busRead(8'h10, 32'h4, "R8 mask readback");

    // R6
    busWrite(8'h0C, 32'h1);
    busRead(8'h0C, 32'h4, "R6 partial clear");
    chk("R6 irqOut still", {31'b0, irqOut}, 1);
    busWrite(8'h0C, 32'h4);
    busRead(8'h0C, 32'h0, "R6 full clear");
    chk("R6 irqOut low", {31'b0, irqOut}, 0);

    // R7: set and clear collide
    busWrite(8'h10, 32'h2);
    @(negedge clk); wrEn = 1; addr = 8'h0C; wrData = 32'h2; irqEvent = 32'h2;
    @(negedge clk); wrEn = 0; irqEvent = 0;
    busRead(8'h0C, 32'h2, "R7 set wins");
    chk("R7 irqOut", {31'b0, irqOut}, 1);

    // R9
    busRead(8'h14, BID, "R9 build id");
    busWrite(8'h14, 32'h0);
    busRead(8'h14, BID, "R9 build id after write");

    // R10
    busRead(8'h18, 32'hC0DE_0000, "R10 entry 0");
    busRead(8'h8C, 32'hC0DE_0000 + 29 * 32'h111, "R10 entry 29");
    busRead(8'h34, 32'hC0DE_0000 + 7 * 32'h111, "R10 entry 7");
    busWrite(8'h24, 32'hCAFE_F00D);
    chk("R10 entry 3 pulse", entryPulse[3*32 +: 32], 32'hCAFE_F00D);
    chk("R10 other entries quiet", 32'((entryPulse & ~({{(NE*32-32){1'b0}}, 32'hFFFF_FFFF} << 96)) != '0), 0);
    chk("R10 no cmd pulse", cmdPulse, 0);
    @(negedge clk);
    chk("R10 pulse gone", 32'(entryPulse != '0), 0);

    // R11
    busRead(8'h90, 0, "R11 past array");
    busRead(8'h01, 0, "R11 misaligned");
    busWrite(8'h90, 32'h1111_1111);
    chk("R11 no pulse", 32'(entryPulse != '0), 0);
    busWrite(8'h02, 32'h2222_2222);
    busWrite(8'h12, 32'h3333_3333);
    busRead(8'h00, 32'hDEAD_BEEF, "R11 cfg unchanged");
    busRead(8'h10, 32'h2, "R11 mask unchanged");

    // R12
    repeat (3) @(negedge clk);
    chk("R12 rdData held", rdData, 32'h2);

    chk("scoreboard drained", 32'(expQ.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule